// File: doc/BRIEF.md
# Interrupt line to vector translator

This block gathers a bank of device interrupt lines and turns each one that is pending, unmasked and message-enabled into a vector message for an upstream vector controller. Every line has its own trigger mode (high level, low level, rising edge or falling edge), a pending bit that software clears by writing ones, an 8-bit vector number and an 8-bit route byte. The outgoing message uses a valid/ready handshake and carries the vector number and route byte of the line being sent.

Software reaches all state through a simple register port. Writes take effect at the next clock edge. Reads are combinational on the address. Line inputs are asynchronous. They pass through a two-flop synchronizer before trigger detection, so a message follows an input change by a fixed number of cycles. When several lines are ready at once, the lowest-numbered line goes first. A line that has been sent is not sent again until its pending bit has been cleared.

Top module: `irq_vec_xlate`

## Requirements
- R1: After reset every mask bit reads 1, every pending bit reads 0, every other register reads 0, and `msg_valid` is low.
- R2: Line n is bit n%32 of word n/32, and word w of a group lives at the group base plus 4*w. The group bases are: mask 0x020, message enable 0x040, edge select 0x060, pending/clear 0x080, spare words 0x0C0 and 0x0E0, polarity 0x3E0. The route byte of line n is at 0x100+n and its vector byte is at 0x200+n. A byte register reads back in bits 7:0 with zeros above. Any other address reads 0.
- R3: A mask bit of 1 stops the line from being sent, but its pending bit is still latched. A mask bit of 0 lets the line through.
- R4: A line is sent only while its message-enable bit is 1.
- R5: The trigger mode is set by the pair {edge, polarity}: 00 is high level, 01 is low level, 10 is rising edge, 11 is falling edge. An edge sets the pending bit, and the bit stays set after the input returns.
- R6: Writing a 1 to a bit at the pending/clear word clears that pending bit, and bits written as 0 are unchanged. Reading that word returns the pending bits. A level line that is still active after a clear becomes pending again on the next cycle.
- R7: A message carries the vector byte and route byte of its line, as they stood when the message was loaded.
- R8: When several lines are eligible, the lowest-numbered line is loaded first.
- R9: A message stays valid with unchanged contents until `msg_ready` is seen. A line is sent once per pending episode and is not sent again until its pending bit has been cleared.
- R10: The two spare words read back what was written and have no effect on behaviour.
- R11: An input change sampled at rising edge k appears in the pending bits after edge k+2, and the resulting message is valid after edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_LINES | Device interrupt lines, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address for reads and writes |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Read data, combinational on bus_addr |
| msg_valid | output | 1 | A vector message is offered |
| msg_ready | input | 1 | Upstream accepts the message |
| msg_vec | output | 8 | Vector number of the offered message |
| msg_route | output | 8 | Route byte of the offered message |

## Verification
A behavioural model in the bench tracks the synchronizer stages, pending and sent state, and the message register. It is compared with the message outputs at every falling clock edge, so the three-edge path from input to pending and the fourth edge that loads the message are both checked in the exact cycle they are due. Register reads are checked a short delay after the address changes, within the same low clock phase. Because writes take effect at the next rising edge, every read that follows a write sees the new value. Clears and mask or enable changes are checked against the model in the cycles that follow them, both through the pending word and through whether a message appears.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

   // Group base addresses (byte offsets); word w of a group sits at base + 4*w
   localparam int unsigned OFS_MASK  = 32'h020;
   localparam int unsigned OFS_EN    = 32'h040;
   localparam int unsigned OFS_EDGE  = 32'h060;
   localparam int unsigned OFS_CLR   = 32'h080;
   localparam int unsigned OFS_AUX0  = 32'h0C0;
   localparam int unsigned OFS_AUX1  = 32'h0E0;
   localparam int unsigned OFS_ROUTE = 32'h100;
   localparam int unsigned OFS_VEC   = 32'h200;
   localparam int unsigned OFS_POL   = 32'h3E0;

   // Trigger mode as {edge, polarity}
   typedef enum logic [1:0] {
      TRIG_LVL_HI = 2'b00,
      TRIG_LVL_LO = 2'b01,
      TRIG_RISE   = 2'b10,
      TRIG_FALL   = 2'b11
   } trig_e;

endpackage

// File: rtl/irq_vec_regs.sv
module irq_vec_regs
   import irq_vec_pkg::*;
#(
   parameter int NUM_LINES = 64,
   parameter int WORD_W    = 32,
   parameter int ADDR_W    = 10
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_wr,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [WORD_W-1:0]         bus_wdata,
   output logic [WORD_W-1:0]         bus_rdata,
   input  logic [NUM_LINES-1:0]      pend_i,
   output logic [NUM_LINES-1:0]      mask_o,
   output logic [NUM_LINES-1:0]      en_o,
   output logic [NUM_LINES-1:0]      edge_o,
   output logic [NUM_LINES-1:0]      pol_o,
   output logic [NUM_LINES-1:0]      clr_o,
   output logic [NUM_LINES-1:0][7:0] route_o,
   output logic [NUM_LINES-1:0][7:0] vec_o
);

   localparam int NUM_WORDS = NUM_LINES / WORD_W;
   localparam int STRIDE    = WORD_W / 8;

   logic [NUM_LINES-1:0]      mask_q, en_q, edge_q, pol_q, aux0_q, aux1_q;
   logic [NUM_LINES-1:0][7:0] route_q, vec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '1;
         en_q    <= '0;
         edge_q  <= '0;
         pol_q   <= '0;
         aux0_q  <= '0;
         aux1_q  <= '0;
         route_q <= '0;
         vec_q   <= '0;
      end else if (bus_wr) begin
         for (int w = 0; w < NUM_WORDS; w++) begin
            if (bus_addr == ADDR_W'(OFS_MASK + w*STRIDE)) mask_q[w*WORD_W +: WORD_W] <= bus_wdata;
            if (bus_addr == ADDR_W'(OFS_EN   + w*STRIDE)) en_q  [w*WORD_W +: WORD_W] <= bus_wdata;
            if (bus_addr == ADDR_W'(OFS_EDGE + w*STRIDE)) edge_q[w*WORD_W +: WORD_W] <= bus_wdata;
            if (bus_addr == ADDR_W'(OFS_POL  + w*STRIDE)) pol_q [w*WORD_W +: WORD_W] <= bus_wdata;
            if (bus_addr == ADDR_W'(OFS_AUX0 + w*STRIDE)) aux0_q[w*WORD_W +: WORD_W] <= bus_wdata;
            if (bus_addr == ADDR_W'(OFS_AUX1 + w*STRIDE)) aux1_q[w*WORD_W +: WORD_W] <= bus_wdata;
         end
         for (int n = 0; n < NUM_LINES; n++) begin
            if (bus_addr == ADDR_W'(OFS_ROUTE + n)) route_q[n] <= bus_wdata[7:0];
            if (bus_addr == ADDR_W'(OFS_VEC   + n)) vec_q[n]   <= bus_wdata[7:0];
         end
      end
   end

   // Write-one-to-clear pulses go straight to the pending logic
   always_comb begin
      clr_o = '0;
      for (int w = 0; w < NUM_WORDS; w++)
         if (bus_wr && bus_addr == ADDR_W'(OFS_CLR + w*STRIDE))
            clr_o[w*WORD_W +: WORD_W] = bus_wdata;
   end

   always_comb begin
      bus_rdata = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (bus_addr == ADDR_W'(OFS_MASK + w*STRIDE)) bus_rdata = mask_q[w*WORD_W +: WORD_W];
         if (bus_addr == ADDR_W'(OFS_EN   + w*STRIDE)) bus_rdata = en_q  [w*WORD_W +: WORD_W];
         if (bus_addr == ADDR_W'(OFS_EDGE + w*STRIDE)) bus_rdata = edge_q[w*WORD_W +: WORD_W];
         if (bus_addr == ADDR_W'(OFS_CLR  + w*STRIDE)) bus_rdata = pend_i[w*WORD_W +: WORD_W];
         if (bus_addr == ADDR_W'(OFS_AUX0 + w*STRIDE)) bus_rdata = aux0_q[w*WORD_W +: WORD_W];
         if (bus_addr == ADDR_W'(OFS_AUX1 + w*STRIDE)) bus_rdata = aux1_q[w*WORD_W +: WORD_W];
         if (bus_addr == ADDR_W'(OFS_POL  + w*STRIDE)) bus_rdata = pol_q [w*WORD_W +: WORD_W];
      end
      for (int n = 0; n < NUM_LINES; n++) begin
         if (bus_addr == ADDR_W'(OFS_ROUTE + n)) bus_rdata = WORD_W'(route_q[n]);
         if (bus_addr == ADDR_W'(OFS_VEC   + n)) bus_rdata = WORD_W'(vec_q[n]);
      end
   end

   assign mask_o  = mask_q;
   assign en_o    = en_q;
   assign edge_o  = edge_q;
   assign pol_o   = pol_q;
   assign route_o = route_q;
   assign vec_o   = vec_q;

endmodule

// File: rtl/irq_vec_trig.sv
module irq_vec_trig
   import irq_vec_pkg::*;
#(
   parameter int NUM_LINES = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_i,
   input  logic [NUM_LINES-1:0] edge_i,
   input  logic [NUM_LINES-1:0] pol_i,
   input  logic [NUM_LINES-1:0] clr_i,
   input  logic [NUM_LINES-1:0] load_i,
   output logic [NUM_LINES-1:0] pend_o,
   output logic [NUM_LINES-1:0] sent_o
);

   logic [NUM_LINES-1:0] sync1_q, sync2_q, prev_q, pend_q, sent_q, hit;

   always_comb begin
      for (int n = 0; n < NUM_LINES; n++) begin
         unique case (trig_e'({edge_i[n], pol_i[n]}))
            TRIG_LVL_HI: hit[n] =  sync2_q[n];
            TRIG_LVL_LO: hit[n] = ~sync2_q[n];
            TRIG_RISE:   hit[n] =  sync2_q[n] & ~prev_q[n];
            TRIG_FALL:   hit[n] = ~sync2_q[n] &  prev_q[n];
            default:     hit[n] = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync1_q <= '0;
         sync2_q <= '0;
         prev_q  <= '0;
         pend_q  <= '0;
         sent_q  <= '0;
      end else begin
         sync1_q <= irq_i;
         sync2_q <= sync1_q;
         prev_q  <= sync2_q;
         pend_q  <= (pend_q | hit) & ~clr_i;
         sent_q  <= (sent_q | load_i) & ~clr_i;
      end
   end

   assign pend_o = pend_q;
   assign sent_o = sent_q;

   assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i != '0) |=> ((pend_q & $past(clr_i)) == '0));

   assert_sent_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((sent_q & ~pend_q) == '0));

endmodule

// File: rtl/irq_vec_arb.sv
module irq_vec_arb #(
   parameter int NUM_LINES = 64
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_LINES-1:0]      pend_i,
   input  logic [NUM_LINES-1:0]      sent_i,
   input  logic [NUM_LINES-1:0]      mask_i,
   input  logic [NUM_LINES-1:0]      en_i,
   input  logic [NUM_LINES-1:0][7:0] route_i,
   input  logic [NUM_LINES-1:0][7:0] vec_i,
   input  logic                      msg_ready,
   output logic [NUM_LINES-1:0]      load_o,
   output logic                      msg_valid,
   output logic [7:0]                msg_vec,
   output logic [7:0]                msg_route
);

   localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

   logic [NUM_LINES-1:0] elig;
   logic [IDX_W-1:0]     pick;
   logic                 found, load;

   assign elig = pend_i & ~sent_i & ~mask_i & en_i;

   // Lowest index wins
   always_comb begin
      pick  = '0;
      found = 1'b0;
      for (int n = 0; n < NUM_LINES; n++) begin
         if (!found && elig[n]) begin
            pick  = IDX_W'(n);
            found = 1'b1;
         end
      end
   end

   assign load = found && (!msg_valid || msg_ready);

   always_comb begin
      load_o = '0;
      if (load) load_o[pick] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_valid <= 1'b0;
         msg_vec   <= '0;
         msg_route <= '0;
      end else if (load) begin
         msg_valid <= 1'b1;
         msg_vec   <= vec_i[pick];
         msg_route <= route_i[pick];
      end else if (msg_ready) begin
         msg_valid <= 1'b0;
      end
   end

   assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vec) && $stable(msg_route)));

   assert_single_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(load_o));

endmodule

// File: rtl/irq_vec_xlate.sv
module irq_vec_xlate
   import irq_vec_pkg::*;
#(
   parameter int NUM_LINES = 64,
   parameter int WORD_W    = 32,
   parameter int ADDR_W    = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_i,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [WORD_W-1:0]    bus_wdata,
   output logic [WORD_W-1:0]    bus_rdata,
   output logic                 msg_valid,
   input  logic                 msg_ready,
   output logic [7:0]           msg_vec,
   output logic [7:0]           msg_route
);

   localparam int NUM_WORDS = NUM_LINES / WORD_W;
   localparam int STRIDE    = WORD_W / 8;

   // Elaboration-time parameter checks
   if (WORD_W % 8 != 0 || WORD_W < 8) begin : g_bad_word
      $fatal(1, "WORD_W must be a whole number of bytes");
   end
   if (NUM_LINES % WORD_W != 0 || NUM_LINES < WORD_W) begin : g_bad_lines
      $fatal(1, "NUM_LINES must be a multiple of WORD_W");
   end
   if (NUM_LINES > 256 || NUM_WORDS * STRIDE > 32) begin : g_bad_span
      $fatal(1, "register groups would overlap");
   end
   if (ADDR_W < 10) begin : g_bad_addr
      $fatal(1, "ADDR_W too small for the register map");
   end

   logic [NUM_LINES-1:0]      mask, en, edge_sel, pol, clr, pend, sent, load;
   logic [NUM_LINES-1:0][7:0] route, vec;

   irq_vec_regs #(.NUM_LINES(NUM_LINES), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .pend_i   (pend),
      .mask_o   (mask),
      .en_o     (en),
      .edge_o   (edge_sel),
      .pol_o    (pol),
      .clr_o    (clr),
      .route_o  (route),
      .vec_o    (vec)
   );

   irq_vec_trig #(.NUM_LINES(NUM_LINES)) u_trig (
      .clk   (clk),
      .rst_n (rst_n),
      .irq_i (irq_i),
      .edge_i(edge_sel),
      .pol_i (pol),
      .clr_i (clr),
      .load_i(load),
      .pend_o(pend),
      .sent_o(sent)
   );

   irq_vec_arb #(.NUM_LINES(NUM_LINES)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend_i   (pend),
      .sent_i   (sent),
      .mask_i   (mask),
      .en_i     (en),
      .route_i  (route),
      .vec_i    (vec),
      .msg_ready(msg_ready),
      .load_o   (load),
      .msg_valid(msg_valid),
      .msg_vec  (msg_vec),
      .msg_route(msg_route)
   );

   // A granted line must be one the mask and enable allowed in that cycle
   assert_grant_allowed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((load & (mask | ~en)) == '0));

endmodule

// File: tb/test_irq_vec_xlate.sv
`timescale 1ns/1ps
module test_irq_vec_xlate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] irq = '0;
   logic        bus_wr = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        msg_valid, msg_ready = 1'b1;
   logic [7:0]  msg_vec, msg_route;

   int    nvec = 0, nfail = 0;
   string tag = "R1";

   always #4 clk = ~clk;

   irq_vec_xlate i_irq_vec_xlate (
      .clk(clk), .rst_n(rst_n), .irq_i(irq), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .msg_valid(msg_valid),
      .msg_ready(msg_ready), .msg_vec(msg_vec), .msg_route(msg_route)
   );

   // ---------------- reference model ----------------
   logic [63:0] s1, s2, pv, pd, st, mk, en, ed, po, a0, a1;
   logic [7:0]  rt [64];
   logic [7:0]  vc [64];
   logic        mv;
   logic [7:0]  mvec, mrt;

   always @(posedge clk or negedge rst_n) begin : model
      logic [63:0] hit, clr, elig;
      int pick;
      if (!rst_n) begin
         s1 = '0; s2 = '0; pv = '0; pd = '0; st = '0;
         mk = '1; en = '0; ed = '0; po = '0; a0 = '0; a1 = '0;
         for (int n = 0; n < 64; n++) begin rt[n] = '0; vc[n] = '0; end
         mv = 1'b0; mvec = '0; mrt = '0;
      end else begin
         for (int n = 0; n < 64; n++) begin
            case ({ed[n], po[n]})
               2'b00:   hit[n] = s2[n];
               2'b01:   hit[n] = !s2[n];
               2'b10:   hit[n] = s2[n] && !pv[n];
               default: hit[n] = !s2[n] && pv[n];
            endcase
         end
         clr = '0;
         if (bus_wr && bus_addr == 10'h080) clr[31:0]  = bus_wdata;
         if (bus_wr && bus_addr == 10'h084) clr[63:32] = bus_wdata;
         elig = pd & ~st & ~mk & en;
         pick = -1;
         for (int n = 63; n >= 0; n--) if (elig[n]) pick = n;
         if (!mv || msg_ready) begin
            if (pick >= 0) begin
               mv = 1'b1; mvec = vc[pick]; mrt = rt[pick]; st[pick] = 1'b1;
            end else mv = 1'b0;
         end
         pd = (pd | hit) & ~clr;
         st = st & ~clr;
         pv = s2; s2 = s1; s1 = irq;
         if (bus_wr) begin
            for (int w = 0; w < 2; w++) begin
               if (bus_addr == 10'(32'h020 + 4*w)) mk[w*32 +: 32] = bus_wdata;
               if (bus_addr == 10'(32'h040 + 4*w)) en[w*32 +: 32] = bus_wdata;
               if (bus_addr == 10'(32'h060 + 4*w)) ed[w*32 +: 32] = bus_wdata;
               if (bus_addr == 10'(32'h0C0 + 4*w)) a0[w*32 +: 32] = bus_wdata;
               if (bus_addr == 10'(32'h0E0 + 4*w)) a1[w*32 +: 32] = bus_wdata;
               if (bus_addr == 10'(32'h3E0 + 4*w)) po[w*32 +: 32] = bus_wdata;
            end
            for (int n = 0; n < 64; n++) begin
               if (bus_addr == 10'(32'h100 + n)) rt[n] = bus_wdata[7:0];
               if (bus_addr == 10'(32'h200 + n)) vc[n] = bus_wdata[7:0];
            end
         end
      end
   end

   function automatic logic [31:0] mread(input logic [9:0] a);
      logic [31:0] r = '0;
      for (int w = 0; w < 2; w++) begin
         if (a == 10'(32'h020 + 4*w)) r = mk[w*32 +: 32];
         if (a == 10'(32'h040 + 4*w)) r = en[w*32 +: 32];
         if (a == 10'(32'h060 + 4*w)) r = ed[w*32 +: 32];
         if (a == 10'(32'h080 + 4*w)) r = pd[w*32 +: 32];
         if (a == 10'(32'h0C0 + 4*w)) r = a0[w*32 +: 32];
         if (a == 10'(32'h0E0 + 4*w)) r = a1[w*32 +: 32];
         if (a == 10'(32'h3E0 + 4*w)) r = po[w*32 +: 32];
      end
      for (int n = 0; n < 64; n++) begin
         if (a == 10'(32'h100 + n)) r = {24'h0, rt[n]};
         if (a == 10'(32'h200 + n)) r = {24'h0, vc[n]};
      end
      return r;
   endfunction

   // ---------------- per-cycle message comparison ----------------
   always @(negedge clk) begin
      if (rst_n) begin
         nvec++;
         if (msg_valid !== mv || (mv && (msg_vec !== mvec || msg_route !== mrt))) begin
            nfail++;
            $display("FAIL %s message at %0t: got v=%b vec=%h rt=%h exp v=%b vec=%h rt=%h",
                     tag, $time, msg_valid, msg_vec, msg_route, mv, mvec, mrt);
         end
      end
   end

   // ---------------- stimulus tasks (called just after a falling edge) ----------------
   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [9:0] a);
      logic [31:0] e;
      bus_addr = a;
      #1;
      e = mread(a);
      nvec++;
      if (bus_rdata !== e) begin
         nfail++;
         $display("FAIL %s read %h: got %h exp %h", tag, a, bus_rdata, e);
      end
      @(negedge clk);
   endtask

   task automatic clear_all();
      wr(10'h080, 32'hFFFF_FFFF);
      wr(10'h084, 32'hFFFF_FFFF);
   endtask

   initial begin : watchdog
      #(8 * 100000);
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin : stim
      cyc(3);
      rst_n = 1'b1;
      cyc(1);

      // R1: reset values
      tag = "R1";
      rd(10'h020); rd(10'h024); rd(10'h040); rd(10'h060); rd(10'h080);
      rd(10'h3E4); rd(10'h0C0); rd(10'h100); rd(10'h23F);

      // R2: byte registers, word placement, unmapped addresses
      tag = "R2";
      for (int n = 0; n < 64; n++) begin
         wr(10'(32'h100 + n), 32'h1);
         wr(10'(32'h200 + n), 32'(8'h40 + n));
      end
      rd(10'h200 + 10'd37); rd(10'h13F); rd(10'h000); rd(10'h030); rd(10'h2FF);
      wr(10'h040, 32'hFFFF_FFFF);
      wr(10'h044, 32'hFFFF_FFFF);
      wr(10'h020, 32'h0);
      wr(10'h024, 32'h0);
      rd(10'h044); rd(10'h024);

      // R8: two level lines at once, lowest first
      tag = "R8";
      irq[40] = 1'b1; irq[3] = 1'b1;
      cyc(8);
      rd(10'h080); rd(10'h084);

      // R9: no repeat while pending stays set
      tag = "R9";
      cyc(6);

      // R6: clear while line still active re-pends and resends
      tag = "R6";
      wr(10'h080, 32'h0000_0008);
      cyc(6);
      irq[3] = 1'b0; irq[40] = 1'b0;
      cyc(3);
      clear_all();
      cyc(3);
      rd(10'h080); rd(10'h084);
      irq[6] = 1'b1;
      cyc(5);
      wr(10'h080, 32'h0);
      rd(10'h080);
      irq[6] = 1'b0;
      cyc(3);
      clear_all();
      cyc(3);

      // R9: hold the message while ready is low
      tag = "R9";
      msg_ready = 1'b0;
      irq[5] = 1'b1; irq[2] = 1'b1;
      cyc(9);
      msg_ready = 1'b1;
      cyc(4);
      irq[5] = 1'b0; irq[2] = 1'b0;
      cyc(3);
      clear_all();
      cyc(3);

      // R3: masked line latches but is not sent until unmasked
      tag = "R3";
      wr(10'h020, 32'h0000_0080);
      irq[7] = 1'b1;
      cyc(6);
      rd(10'h080);
      wr(10'h020, 32'h0);
      cyc(5);
      irq[7] = 1'b0;
      cyc(3);
      clear_all();
      cyc(3);

      // R4: message enable gates sending
      tag = "R4";
      wr(10'h040, 32'hFFFF_FDFF);
      irq[9] = 1'b1;
      cyc(6);
      rd(10'h080);
      wr(10'h040, 32'hFFFF_FFFF);
      cyc(5);
      irq[9] = 1'b0;
      cyc(3);
      clear_all();
      cyc(3);

      // R5: rising (10, 33), falling (11), low level (12)
      tag = "R5";
      irq[11] = 1'b1;
      wr(10'h060, 32'h0000_0C00);
      wr(10'h064, 32'h0000_0002);
      cyc(4);
      wr(10'h3E0, 32'h0000_0800);
      cyc(4);
      rd(10'h080);
      irq[10] = 1'b1; irq[33] = 1'b1;
      cyc(1);
      irq[10] = 1'b0; irq[33] = 1'b0;
      cyc(6);
      rd(10'h080); rd(10'h084);
      irq[11] = 1'b0;
      cyc(6);
      rd(10'h080);
      clear_all();
      cyc(4);
      rd(10'h080); rd(10'h084);
      wr(10'h3E0, 32'h0000_1800);
      cyc(5);
      rd(10'h080);
      irq[12] = 1'b1;
      cyc(3);
      wr(10'h080, 32'h0000_1000);
      cyc(4);
      rd(10'h080); rd(10'h3E0);

      // R10: spare words are storage only
      tag = "R10";
      wr(10'h0C0, 32'h1234_5678);
      wr(10'h0E4, 32'hDEAD_BEEF);
      rd(10'h0C0); rd(10'h0E4); rd(10'h0C4);

      // R7: per-line vector and route bytes
      tag = "R7";
      wr(10'h114, 32'h0000_0003);
      wr(10'h214, 32'h0000_00EE);
      irq[20] = 1'b1;
      cyc(6);
      irq[20] = 1'b0;
      cyc(3);
      clear_all();
      cyc(3);

      // R11: input to pending and message latency
      tag = "R11";
      irq[50] = 1'b1;
      cyc(1);
      rd(10'h084);
      rd(10'h084);
      rd(10'h084);
      cyc(3);
      irq[50] = 1'b0;
      cyc(3);
      clear_all();
      cyc(4);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule